// File: doc/BRIEF.md
# Serial Register Port with Streaming Motion Read

This block is the device side of a four-wire serial port. It runs in clock-polarity-high mode: SCLK idles high, the controller changes MOSI while SCLK is low, and the block takes MOSI on each rising SCLK edge. The port gives a host controller access to a 7-bit register space.

Every command is two bytes long. The first byte selects the direction and the register. The second byte is either write data on MOSI or read data returned on MISO. The three serial inputs are oversampled in the system clock domain. The block drives single-cycle read and write strobes toward a register file. That register file returns read data combinationally in the same cycle as the read strobe.

One command address is special. A read of it does not fetch that address. It starts a streaming read of seven consecutive motion registers, with no gap between bytes. Once the last of those registers has been sent, further clocking returns that last register again. While this streaming read is running, the port decodes nothing else. It returns to normal operation only after chip select is raised. Raising chip select at any point also cancels a half-finished command.

Top module: `spi_burst_slave`

## Requirements
- R1: A command whose first byte has bit 7 set is a write. Bits 6..0 of that byte are the address, and the second byte is the data, both sent MSB first. After the 16th rising SCLK edge the block raises `reg_wr_en` for exactly one clock, with `reg_wr_addr` and `reg_wr_data` holding those values. `reg_wr_en` and `reg_rd_en` are never high together.
- R2: A command whose first byte has bit 7 clear is a read of the address in bits 6..0. After the 8th rising edge the block raises `reg_rd_en` for one clock with that address and captures `reg_rd_data`. MISO presents bit 7 of that data before the 9th rising edge. Each later bit appears after a falling edge, and MISO does not change at any other time while the port is selected.
- R3: While `spi_cs_n` is high, SCLK and MOSI activity produces no strobe and `spi_miso_oe` is low.
- R4: Raising `spi_cs_n` before the 16th rising edge of a write discards it, with no write strobe. The next command after chip select falls again is decoded from a fresh first byte.
- R5: A read of address 0x63 starts a streaming read. The bytes returned are the registers at 0x03, 0x04, 0x05, 0x06, 0x07, 0x08 and 0x09, in that order and back to back. Each one is fetched with its own read strobe.
- R6: If clocking continues past the seventh streamed byte, the address stays at 0x09 and that register is returned again for every further byte.
- R7: Once a streaming read has started, MOSI bytes are not decoded and no write strobe is produced until `spi_cs_n` has been raised. After that, normal commands work again.
- R8: Without a streaming read, several two-byte commands may follow one another inside a single chip-select frame, and each is decoded.
- R9: After reset, `spi_miso_oe`, `reg_wr_en` and `reg_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller, idles high |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso_o | output | 1 | Serial data to the controller |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_addr | output | 7 | Register read address |
| reg_rd_data | input | 8 | Read data, valid in the cycle of `reg_rd_en` |

## Verification
The MISO stability property assumes the controller keeps SCLK high and low for at least two system clocks each. Under that assumption a falling edge cannot land in the cycle where a read strobe is still being answered. The stimulus holds each SCLK phase for eight system clocks, changes MOSI only while SCLK is low, and moves chip select only while SCLK is high and idle. The register file model answers every read strobe combinationally from the address alone, so the captured byte is fully determined by the strobe.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  // Command-level phase of the serial port.
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,  // collecting direction + address byte
    PH_DATA  = 2'd1,  // single data byte (read or write)
    PH_BURST = 2'd2   // streaming read, locked until chip select rises
  } phase_t;

  // Saturating successor of a streaming index.
  function automatic logic [7:0] sat_next(input logic [7:0] idx, input int unsigned last);
    if (idx >= 8'(last)) return 8'(last);
    return idx + 8'd1;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{RST_VAL[b]}};
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
      end
    end

    assign sync_o[b] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_burst_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          DATA_W     = 8,
  parameter int          BURST_LEN  = 7,
  parameter logic [ADDR_W-1:0] BURST_CMD  = 7'h63,
  parameter logic [ADDR_W-1:0] BURST_BASE = 7'h03,
  localparam int         BIT_W      = $clog2(DATA_W),
  localparam int         IDX_W      = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              mosi,
  output phase_t            phase_o,
  output logic [BIT_W-1:0]  bcnt_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              load_first_o,
  output logic              prefetch_o
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);
  localparam int unsigned      IDX_LAST = BURST_LEN - 1;

  phase_t              phase_q, phase_d;
  logic [BIT_W-1:0]    bcnt_q, bcnt_d;
  logic [DATA_W-2:0]   sh_q, sh_d;
  logic                dir_q, dir_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [IDX_W-1:0]    bidx_q, bidx_d;

  logic                wr_en_q, wr_en_d;
  logic [ADDR_W-1:0]   wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0]   wr_data_q, wr_data_d;
  logic                rd_en_q, rd_en_d;
  logic [ADDR_W-1:0]   rd_addr_q, rd_addr_d;
  logic                load_first_q, load_first_d;
  logic                prefetch_q, prefetch_d;

  logic [DATA_W-1:0]   shin;
  logic [IDX_W-1:0]    bidx_nx;

  assign shin    = {sh_q, mosi};
  assign bidx_nx = IDX_W'(sat_next(8'(bidx_q), IDX_LAST));

  // Next-state process.
  always_comb begin
    phase_d      = phase_q;
    bcnt_d       = bcnt_q;
    sh_d         = sh_q;
    dir_d        = dir_q;
    addr_d       = addr_q;
    bidx_d       = bidx_q;
    wr_en_d      = 1'b0;
    wr_addr_d    = wr_addr_q;
    wr_data_d    = wr_data_q;
    rd_en_d      = 1'b0;
    rd_addr_d    = rd_addr_q;
    load_first_d = 1'b0;
    prefetch_d   = 1'b0;

    if (!cs_act) begin
      phase_d = PH_ADDR;
      bcnt_d  = '0;
      bidx_d  = '0;
    end else if (sclk_rise) begin
      bcnt_d = bcnt_q + 1'b1;
      sh_d   = shin[DATA_W-2:0];
      if (bcnt_q == BIT_LAST) begin
        unique case (phase_q)
          PH_ADDR: begin
            dir_d   = shin[DATA_W-1];
            addr_d  = shin[ADDR_W-1:0];
            phase_d = PH_DATA;
            if (!shin[DATA_W-1]) begin
              rd_en_d      = 1'b1;
              load_first_d = 1'b1;
              if (shin[ADDR_W-1:0] == BURST_CMD) begin
                rd_addr_d = BURST_BASE;
                bidx_d    = '0;
                phase_d   = PH_BURST;
              end else begin
                rd_addr_d = shin[ADDR_W-1:0];
              end
            end
          end
          PH_DATA: begin
            if (dir_q) begin
              wr_en_d   = 1'b1;
              wr_addr_d = addr_q;
              wr_data_d = shin;
            end
            phase_d = PH_ADDR;
          end
          PH_BURST: begin
            bidx_d     = bidx_nx;
            rd_en_d    = 1'b1;
            rd_addr_d  = BURST_BASE + ADDR_W'(bidx_nx);
            prefetch_d = 1'b1;
          end
          default: phase_d = PH_ADDR;
        endcase
      end
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_ADDR;
      bcnt_q       <= '0;
      sh_q         <= '0;
      dir_q        <= 1'b0;
      addr_q       <= '0;
      bidx_q       <= '0;
      wr_en_q      <= 1'b0;
      wr_addr_q    <= '0;
      wr_data_q    <= '0;
      rd_en_q      <= 1'b0;
      rd_addr_q    <= '0;
      load_first_q <= 1'b0;
      prefetch_q   <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      bcnt_q       <= bcnt_d;
      sh_q         <= sh_d;
      dir_q        <= dir_d;
      addr_q       <= addr_d;
      bidx_q       <= bidx_d;
      wr_en_q      <= wr_en_d;
      wr_addr_q    <= wr_addr_d;
      wr_data_q    <= wr_data_d;
      rd_en_q      <= rd_en_d;
      rd_addr_q    <= rd_addr_d;
      load_first_q <= load_first_d;
      prefetch_q   <= prefetch_d;
    end
  end

  assign phase_o      = phase_q;
  assign bcnt_o       = bcnt_q;
  assign wr_en_o      = wr_en_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;
  assign rd_en_o      = rd_en_q;
  assign rd_addr_o    = rd_addr_q;
  assign load_first_o = load_first_q;
  assign prefetch_o   = prefetch_q;

  AST_ABORT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase_q == PH_ADDR && bcnt_q == '0 && !wr_en_q)) else $error("abort"); // R4

  AST_BURST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_BURST |-> !wr_en_q) else $error("write during burst"); // R7

  AST_BURST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_q && phase_q == PH_BURST) |->
      (rd_addr_q >= BURST_BASE && rd_addr_q <= BURST_BASE + ADDR_W'(IDX_LAST))) else $error("burst addr"); // R6

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  phase_t            phase,
  input  logic [BIT_W-1:0]  bcnt,
  input  logic              load_first,
  input  logic              prefetch,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso_o
);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              pend_q, pend_d;
  logic              shift_ok;

  // A falling edge advances the byte only once its first bit was sampled.
  assign shift_ok = (phase != PH_ADDR) && (bcnt != '0);

  always_comb begin
    tx_d   = tx_q;
    hold_d = hold_q;
    pend_d = pend_q;
    if (!cs_act) begin
      tx_d   = '0;
      pend_d = 1'b0;
    end else begin
      if (load_first) begin
        tx_d = rd_data;
      end else if (prefetch) begin
        hold_d = rd_data;
        pend_d = 1'b1;
      end
      if (sclk_fall) begin
        if (pend_q) begin
          tx_d   = hold_q;
          pend_d = 1'b0;
        end else if (shift_ok) begin
          tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign miso_o = tx_q[DATA_W-1];

  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$past(sclk_fall) && !$past(load_first)) |-> $stable(miso_o))
    else $error("miso moved"); // R2

endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import spi_burst_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter int                DATA_W     = 8,
  parameter int                SYNC_STG   = 2,
  parameter int                BURST_LEN  = 7,
  parameter logic [ADDR_W-1:0] BURST_CMD  = 7'h63,
  parameter logic [ADDR_W-1:0] BURST_BASE = 7'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso_o,
  output logic              spi_miso_oe,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [2:0]       pins_sync;
  logic             cs_sync, sclk_sync, mosi_sync;
  logic             sclk_prev_q, sclk_prev_d;
  logic             sclk_rise, sclk_fall, cs_act;
  phase_t           phase;
  logic [BIT_W-1:0] bcnt;
  logic             load_first, prefetch;

  // Bit 2: chip select, bit 1: serial clock, bit 0: data in. Both idle high.
  spi_in_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({spi_cs_n, spi_sclk, spi_mosi}),
    .sync_o  (pins_sync)
  );

  assign cs_sync   = pins_sync[2];
  assign sclk_sync = pins_sync[1];
  assign mosi_sync = pins_sync[0];
  assign cs_act    = ~cs_sync;

  assign sclk_prev_d = sclk_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk_prev_d;
  end

  assign sclk_rise = cs_act &  sclk_sync & ~sclk_prev_q;
  assign sclk_fall = cs_act & ~sclk_sync &  sclk_prev_q;

  spi_rx_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN),
    .BURST_CMD(BURST_CMD), .BURST_BASE(BURST_BASE)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .sclk_rise    (sclk_rise),
    .mosi         (mosi_sync),
    .phase_o      (phase),
    .bcnt_o       (bcnt),
    .wr_en_o      (reg_wr_en),
    .wr_addr_o    (reg_wr_addr),
    .wr_data_o    (reg_wr_data),
    .rd_en_o      (reg_rd_en),
    .rd_addr_o    (reg_rd_addr),
    .load_first_o (load_first),
    .prefetch_o   (prefetch)
  );

  spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sclk_fall  (sclk_fall),
    .phase      (phase),
    .bcnt       (bcnt),
    .load_first (load_first),
    .prefetch   (prefetch),
    .rd_data    (reg_rd_data),
    .miso_o     (spi_miso_o)
  );

  assign spi_miso_oe = cs_act;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)) else $error("both strobes"); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sync && $past(cs_sync)) |-> (!reg_wr_en && !reg_rd_en)) else $error("strobe while idle"); // R3

endmodule

// File: tb/spi_burst_slave_tb.sv
module spi_burst_slave_tb;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_miso_o, spi_miso_oe;
  logic       reg_wr_en, reg_rd_en;
  logic [6:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int hold_miss = 0;
  logic [6:0] wr_a;
  logic [7:0] wr_d;
  logic [6:0] rd_log [0:31];
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] model(input logic [6:0] a);
    return {a, 1'b1} ^ 8'h3C;
  endfunction

  assign reg_rd_data = model(reg_rd_addr);

  spi_burst_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  always @(negedge clk) begin
    if (reg_wr_en) begin
      wr_cnt++;
      wr_a = reg_wr_addr;
      wr_d = reg_wr_data;
    end
    if (reg_rd_en) begin
      if (rd_cnt < 32) rd_log[rd_cnt] = reg_rd_addr;
      rd_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  // One byte, MSB first; MOSI set while SCLK low, MISO taken just before the rise.
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic mid;
      spi_sclk = 1'b0;
      spi_mosi = tx[i];
      wait_clk(HALF / 2 + 1);
      mid = spi_miso_o;
      wait_clk(HALF / 2 - 1);
      rx[i] = spi_miso_o;
      if (spi_cs_n == 1'b0 && mid !== rx[i]) hold_miss++;
      spi_sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  localparam logic [15:0] VEC [6] = '{
    16'h8512, 16'h1100, 16'hFFA5, 16'h0000, 16'h807E, 16'h7F00
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int w0, r0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R9: quiet after reset
    check("R9 oe", spi_miso_oe, 0);
    check("R9 wr", wr_cnt, 0);
    check("R9 rd", rd_cnt, 0);

    // Vector table: writes (R1) and plain reads (R2)
    for (int v = 0; v < 6; v++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      cs_low();
      check("R3 oe active", spi_miso_oe, 1);
      xfer(VEC[v][15:8], rx);
      xfer(VEC[v][7:0], rx);
      cs_high();
      if (VEC[v][15]) begin
        check("R1 count", wr_cnt, w0 + 1);
        check("R1 addr", wr_a, VEC[v][14:8]);
        check("R1 data", wr_d, VEC[v][7:0]);
        check("R1 no read", rd_cnt, r0);
      end else begin
        check("R2 data", rx, model(VEC[v][14:8]));
        check("R2 count", rd_cnt, r0 + 1);
        check("R2 addr", rd_log[r0], VEC[v][14:8]);
        check("R2 no write", wr_cnt, w0);
      end
    end

    // R3: bus activity with chip select high is ignored
    w0 = wr_cnt; r0 = rd_cnt;
    xfer(8'h81, rx);
    xfer(8'hEE, rx);
    wait_clk(4 * HALF);
    check("R3 wr", wr_cnt, w0);
    check("R3 rd", rd_cnt, r0);
    check("R3 oe", spi_miso_oe, 0);

    // R4: aborted write, then a clean write
    w0 = wr_cnt;
    cs_low();
    xfer(8'h8A, rx);
    for (int i = 0; i < 4; i++) begin
      spi_sclk = 1'b0; spi_mosi = 1'b1; wait_clk(HALF);
      spi_sclk = 1'b1; wait_clk(HALF);
    end
    cs_high();
    check("R4 no strobe", wr_cnt, w0);
    cs_low();
    xfer(8'h8A, rx);
    xfer(8'h55, rx);
    cs_high();
    check("R4 fresh count", wr_cnt, w0 + 1);
    check("R4 fresh addr", wr_a, 7'h0A);
    check("R4 fresh data", wr_d, 8'h55);

    // R8: write then read in one frame
    w0 = wr_cnt; r0 = rd_cnt;
    cs_low();
    xfer(8'hA0, rx);
    xfer(8'h66, rx);
    xfer(8'h21, rx);
    xfer(8'h00, rx);
    cs_high();
    check("R8 write", wr_cnt, w0 + 1);
    check("R8 wdata", {25'd0, wr_a, wr_d}, {25'd0, 7'h20, 8'h66});
    check("R8 read", rx, model(7'h21));
    check("R8 rd count", rd_cnt, r0 + 1);

    // R5 / R6: streaming read, nine bytes
    r0 = rd_cnt;
    cs_low();
    xfer(8'h63, rx);
    for (int b = 0; b < 9; b++) begin
      logic [6:0] ea;
      ea = (b < 7) ? 7'(3 + b) : 7'h09;
      xfer(8'h00, rx);
      if (b < 7) check("R5 burst byte", rx, model(ea));
      else       check("R6 repeat byte", rx, model(ea));
    end
    check("R5 first addr", rd_log[r0], 7'h03);
    check("R6 last addr", rd_log[r0 + 9], 7'h09);

    // R7: locked until chip select rises
    w0 = wr_cnt;
    xfer(8'h80, rx);
    check("R7 still streaming", rx, model(7'h09));
    xfer(8'h44, rx);
    check("R7 no decode", rx, model(7'h09));
    cs_high();
    check("R7 no write", wr_cnt, w0);
    cs_low();
    xfer(8'hB0, rx);
    xfer(8'h99, rx);
    cs_high();
    check("R7 unlocked", wr_cnt, w0 + 1);
    check("R7 unlocked data", {25'd0, wr_a, wr_d}, {25'd0, 7'h30, 8'h99});

    // R2: MISO never moved in the middle of a low phase
    check("R2 hold", hold_miss, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule